// File: doc/BRIEF.md
# Mailbox Channel Interrupt Combiner

This block collects interrupt sources for a set of mailbox channels into one interrupt line. Each channel supplies two sources: data waiting (its queue is not empty) and room available (its queue is not full). Every channel has two 2-bit registers that software owns. The enable register selects which sources may latch. The flag register holds the latched sources, and software clears a flag by writing 1 to its bit.

Conditions are sampled as levels on every clock. A source latches into its flag only while its enable bit is set. After that the flag stays set until software clears it, even if the condition goes away. The interrupt output is the OR, over all channels, of each flag ANDed with its enable.

The register decode sits outside this block. It supplies one write strobe per channel for each register, plus a shared write-data bus that holds two bits per channel. The current register contents come back out so that the decode can return them on reads.

Top module: `mbx_irq_combiner`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, every flag bit and every enable bit is 0 and `irq` is low.
- R2: Flag bit 0 of a channel (data waiting) is 1 after a clock edge at which that channel's `q_empty` was 0 and its enable bit 0 was 1, unless that edge also cleared the bit.
- R3: Flag bit 1 of a channel (room available) is 1 after a clock edge at which that channel's `q_full` was 0 and its enable bit 1 was 1, unless that edge also cleared the bit.
- R4: A flag bit never goes from 0 to 1 at an edge where its enable bit was 0, whatever the condition.
- R5: At an edge where a channel's `flag_we` is high, each flag bit whose `wr_data` bit is 1 becomes 0. A `wr_data` bit of 0 leaves that flag bit unchanged. Channel c uses `wr_data[2c+1:2c]`, and bit 2c is the data-waiting source.
- R6: When a clear and a set reach the same bit at the same edge, the bit is 0 after that edge. If the condition and the enable still hold, the bit is 1 again after the next edge.
- R7: `irq` is high exactly when some channel has a flag bit and its matching enable bit both set.
- R8: Clearing an enable bit drops that source from `irq` in the cycle after the write edge. The flag bit itself stays latched.
- R9: A write with `en_we` high loads the channel's enable bits from `wr_data` at that edge. The new enable first gates flag setting at the following edge.
- R10: A set flag bit stays set when its condition goes false, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_empty | input | CHANNELS | Per-channel queue empty level |
| q_full | input | CHANNELS | Per-channel queue full level |
| flag_we | input | CHANNELS | Per-channel flag register write strobe (write-one-to-clear) |
| en_we | input | CHANNELS | Per-channel enable register write strobe |
| wr_data | input | 2*CHANNELS | Write data, two bits per channel |
| flag_q | output | 2*CHANNELS | Current flag bits, two per channel |
| en_q | output | 2*CHANNELS | Current enable bits, two per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong flag or enable bit shows on `flag_q` or `en_q` in the cycle after the edge that stored it. When the bit is enabled, it shows on `irq` in that same cycle. The bench therefore compares both register vectors and `irq` after every edge, so any divergence from the model is caught within one clock. Latching depends on earlier cycles, so the directed cases cover clear-versus-set collisions, conditions that fall while a flag is held, and the one-edge delay of enable writes. Each of these would otherwise show only a few cycles later.

// File: rtl/mbx_irq_combiner.sv
module mbx_irq_combiner #(
  parameter int CHANNELS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CHANNELS-1:0]   q_empty,
  input  logic [CHANNELS-1:0]   q_full,
  input  logic [CHANNELS-1:0]   flag_we,
  input  logic [CHANNELS-1:0]   en_we,
  input  logic [2*CHANNELS-1:0] wr_data,
  output logic [2*CHANNELS-1:0] flag_q,
  output logic [2*CHANNELS-1:0] en_q,
  output logic                  irq
);
  localparam int NB = 2 * CHANNELS;

  logic [NB-1:0] cond, clr;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    assign cond[2*c]   = ~q_empty[c];
    assign cond[2*c+1] = ~q_full[c];
    assign clr[2*c+:2] = flag_we[c] ? wr_data[2*c+:2] : 2'b00;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        en_q[2*c+:2] <= 2'b00;
      else if (en_we[c]) en_q[2*c+:2] <= wr_data[2*c+:2];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q | (cond & en_q)) & ~clr;

  assign irq = |(flag_q & en_q);

  always_comb
    if (!rst_n) a_r1_reset_clear: assert (flag_q == '0 && en_q == '0 && !irq);

  for (genvar b = 0; b < NB; b++) begin : g_chk
    a_r4_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[b]) |-> $past(en_q[b]));
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr[b] |=> !flag_q[b]);
    a_r2_r3_set_on_level: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[b] && en_q[b] && !clr[b]) |=> flag_q[b]);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[b] && !clr[b]) |=> flag_q[b]);
  end
endmodule

// File: tb/mbx_irq_combiner_test.sv
`timescale 1ns/1ps
module mbx_irq_combiner_test;
  localparam int CH = 2;
  localparam int NB = 2 * CH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CH-1:0] q_empty = '1, q_full = '0, flag_we = '0, en_we = '0;
  logic [NB-1:0] wr_data = '0;
  logic [NB-1:0] flag_q, en_q;
  logic irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [NB-1:0] m_flag = '0, m_en = '0;

  always #2.5 clk = ~clk;

  mbx_irq_combiner #(.CHANNELS(CH)) uut (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_full(q_full),
    .flag_we(flag_we), .en_we(en_we), .wr_data(wr_data),
    .flag_q(flag_q), .en_q(en_q), .irq(irq));

  function automatic logic [NB-1:0] next_flag(logic [NB-1:0] f, logic [NB-1:0] e,
      logic [CH-1:0] emp, logic [CH-1:0] ful, logic [CH-1:0] fwe, logic [NB-1:0] wd);
    logic [NB-1:0] r = f;
    for (int c = 0; c < CH; c++) begin
      if (!emp[c] && e[2*c])   r[2*c]   = 1'b1;
      if (!ful[c] && e[2*c+1]) r[2*c+1] = 1'b1;
      if (fwe[c]) r[2*c+:2] = r[2*c+:2] & ~wd[2*c+:2];
    end
    return r;
  endfunction

  function automatic logic [NB-1:0] next_en(logic [NB-1:0] e, logic [CH-1:0] ewe,
      logic [NB-1:0] wd);
    logic [NB-1:0] r = e;
    for (int c = 0; c < CH; c++) if (ewe[c]) r[2*c+:2] = wd[2*c+:2];
    return r;
  endfunction

  task automatic check(string tag, logic [NB-1:0] ef, logic [NB-1:0] ee, logic ei);
    n_vec++;
    if (flag_q !== ef || en_q !== ee || irq !== ei) begin
      n_bad++;
      $display("FAIL %s: flag=%b en=%b irq=%b expected flag=%b en=%b irq=%b",
               tag, flag_q, en_q, irq, ef, ee, ei);
    end
  endtask

  task automatic step(logic [CH-1:0] emp, logic [CH-1:0] ful, logic [CH-1:0] fwe,
                      logic [CH-1:0] ewe, logic [NB-1:0] wd);
    q_empty = emp; q_full = ful; flag_we = fwe; en_we = ewe; wr_data = wd;
    @(posedge clk);
    m_flag = next_flag(m_flag, m_en, emp, ful, fwe, wd);
    m_en   = next_en(m_en, ewe, wd);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    step('1, '0, '0, '0, '0);
    check("R1 after reset", '0, '0, 1'b0);
    step(2'b00, 2'b00, '0, '0, '0);
    check("R4 disabled sources stay low", 4'b0000, 4'b0000, 1'b0);
    step(2'b00, 2'b00, '0, 2'b01, 4'b0011);
    check("R9 enable loaded, not yet gating", 4'b0000, 4'b0011, 1'b0);
    step(2'b00, 2'b00, '0, '0, '0);
    check("R2 R3 sources latch", 4'b0011, 4'b0011, 1'b1);
    step(2'b01, 2'b01, '0, '0, '0);
    check("R10 held after condition drops", 4'b0011, 4'b0011, 1'b1);
    step(2'b01, 2'b01, 2'b01, '0, 4'b0001);
    check("R5 write one clears", 4'b0010, 4'b0011, 1'b1);
    step(2'b01, 2'b01, 2'b01, '0, 4'b0000);
    check("R5 write zero keeps", 4'b0010, 4'b0011, 1'b1);
    step(2'b00, 2'b01, 2'b01, '0, 4'b0001);
    check("R6 clear wins same edge", 4'b0010, 4'b0011, 1'b1);
    step(2'b00, 2'b01, '0, '0, '0);
    check("R6 sets again next edge", 4'b0011, 4'b0011, 1'b1);
    step(2'b01, 2'b01, '0, 2'b01, 4'b0000);
    check("R8 enable off hides flag", 4'b0011, 4'b0000, 1'b0);
    step(2'b01, 2'b01, 2'b01, 2'b10, 4'b0111);
    check("R9 channel 1 enable", 4'b0000, 4'b0100, 1'b0);
    step(2'b01, 2'b11, '0, '0, '0);
    check("R7 other channel drives irq", 4'b0100, 4'b0100, 1'b1);
    m_flag = flag_q; m_en = en_q;
    for (int i = 0; i < 3000; i++) begin
      logic [CH-1:0] fw, ew;
      fw = (($urandom % 4) == 0) ? CH'($urandom) : '0;
      ew = (($urandom % 5) == 0) ? CH'($urandom) : '0;
      step(CH'($urandom), CH'($urandom), fw, ew, NB'($urandom));
      check("R2 R3 R5 R7 random", m_flag, m_en, |(m_flag & m_en));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule